// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block runs one conversion request against an external sampling converter and turns a burst of raw 12-bit samples into a single averaged result. When a start is accepted it latches the requested channel and drives it to the analog multiplexer. It waits a selectable settling time of 20 or 40 converter clocks and ignores any samples that arrive in that window. It then sums a power-of-two number of valid samples, from 1 to 64. At the end it divides the sum by that count with a right shift. The result is presented as offset binary, or as two's complement formed by flipping the most significant bit.

Completion is marked by a one-cycle done strobe and a sticky end-of-conversion flag. The flag stays high until the next accepted start. A soft reset input cancels a conversion in flight at any time. Start requests for channel codes outside the implemented range are dropped, and so are start requests that arrive while a conversion is running.

Top module: `adc_avg_seq`

## Requirements
- R1: Averaging code k in 0..6 takes 2^k samples per result (1, 2, 4, 8, 16, 32, 64); code 7 behaves as code 6 (64 samples).
- R2: result_o is floor(sum of the taken samples / sample count), 12 bits wide, range 0x000..0xFFF.
- R3: After a start is accepted, samples presented on the next L clock edges are discarded, with L = 40 for lat_sel_i = 0 and L = 20 for lat_sel_i = 1; the first sample is taken on edge L+1.
- R4: fmt_sel_i = 1 gives the offset-binary average unchanged; fmt_sel_i = 0 gives the same value with bit 11 inverted (two's complement).
- R5: done_o is high for exactly one cycle, following the clock edge that takes the last sample; result_o and eoc_o=1 become valid at that same edge, and busy_o falls there.
- R6: eoc_o is low from the edge that accepts a start until the result is written, and busy_o is high over the same span.
- R7: soft_rst_i returns the sequencer to idle on the next edge with no done_o pulse and leaves eoc_o low; a later conversion does not include any partial sum.
- R8: A start with chan_i in 0xA..0xF is ignored: busy_o stays low, and chan_sel_o and eoc_o keep their values.
- R9: chan_sel_o takes chan_i on the accepting edge and holds it for the whole conversion; start_i while busy is ignored.
- R10: After rst_ni, busy_o, done_o and eoc_o are 0, result_o is 0x000 and chan_sel_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request |
| soft_rst_i | input | 1 | Synchronous abort to idle |
| chan_i | input | 4 | Requested channel, 0..9 valid |
| avg_code_i | input | 3 | Samples per result = 2^code |
| lat_sel_i | input | 1 | 0: 40-clock settle, 1: 20-clock settle |
| fmt_sel_i | input | 1 | 1: offset binary, 0: two's complement |
| smp_valid_i | input | 1 | Sample strobe from converter |
| smp_data_i | input | 12 | Raw sample |
| chan_sel_o | output | 4 | Channel to the analog multiplexer |
| result_o | output | 12 | Averaged result |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | End-of-conversion flag |

## Verification
A constant sample checks the single-sample path. Linear ramps over every averaging code separate a correct count and shift from an off-by-one count, because each extra or missing ramp sample moves the quotient. During the settling window the sample strobe is held high with 0xFFF. Any premature capture therefore changes the result and moves done_o earlier, for both latency settings. Mid-scale values on either side of 0x800 in both formats expose a wrong bit flip. Aborted runs, reserved channels and starts issued while busy show whether state leaks into the next result or the channel output.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SAMPLE
  } seq_state_e;
endpackage

// File: rtl/adc_avg_ctrl.sv
module adc_avg_ctrl
  import adc_avg_pkg::*;
#(
  parameter int CH_W      = 4,
  parameter int NUM_CH    = 10,
  parameter int CODE_W    = 3,
  parameter int MAX_CODE  = 6,
  parameter int LAT_LONG  = 40,
  parameter int LAT_SHORT = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              soft_rst_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [CODE_W-1:0] avg_code_i,
  input  logic              lat_sel_i,
  input  logic              smp_valid_i,
  output logic [CH_W-1:0]   chan_o,
  output logic [CODE_W-1:0] code_o,
  output logic              clr_o,
  output logic              add_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              eoc_o
);
  localparam int LAT_W = $clog2(LAT_LONG);
  localparam int CNT_W = MAX_CODE + 1;

  seq_state_e        state_q;
  logic [LAT_W-1:0]  wait_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  target;
  logic [CODE_W-1:0] code_eff;
  logic              accept;

  assign code_eff = (avg_code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : avg_code_i;
  assign accept   = (state_q == ST_IDLE) && start_i && !soft_rst_i && (chan_i < CH_W'(NUM_CH));
  assign target   = (CNT_W'(1) << code_o) - CNT_W'(1);
  assign clr_o    = accept;
  assign add_o    = (state_q == ST_SAMPLE) && smp_valid_i && !soft_rst_i;
  assign last_o   = add_o && (cnt_q == target);
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      cnt_q   <= '0;
      chan_o  <= '0;
      code_o  <= '0;
      done_o  <= 1'b0;
      eoc_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (soft_rst_i) begin
        state_q <= ST_IDLE;
        wait_q  <= '0;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (accept) begin
            state_q <= ST_WAIT;
            chan_o  <= chan_i;
            code_o  <= code_eff;
            wait_q  <= lat_sel_i ? LAT_W'(LAT_SHORT - 1) : LAT_W'(LAT_LONG - 1);
            cnt_q   <= '0;
            eoc_o   <= 1'b0;
          end
          ST_WAIT: begin
            if (wait_q == '0) state_q <= ST_SAMPLE;
            else              wait_q  <= wait_q - LAT_W'(1);
          end
          ST_SAMPLE: if (add_o) begin
            if (last_o) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              eoc_o   <= 1'b1;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // sample counter never passes the selected burst length
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMPLE) |-> (cnt_q <= target));

  // no sample is taken while settling
  p_no_early_add_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> !($past(add_o)));
endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc #(
  parameter int DATA_W   = 12,
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic              last_i,
  input  logic              fmt_sel_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int ACC_W = DATA_W + MAX_CODE;

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  sum_next;
  logic [ACC_W-1:0]  shifted;
  logic [DATA_W-1:0] avg;
  logic [DATA_W-1:0] fmt_res;
  logic              fmt_q;

  assign sum_next = acc_q + ACC_W'(data_i);
  assign shifted  = sum_next >> code_i;
  assign avg      = shifted[DATA_W-1:0];
  // two's complement = offset binary with the sign bit flipped
  assign fmt_res  = fmt_q ? avg : {~avg[DATA_W-1], avg[DATA_W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      fmt_q    <= 1'b1;
      result_o <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      fmt_q <= fmt_sel_i;
    end else if (last_i) begin
      acc_q    <= '0;
      result_o <= fmt_res;
    end else if (add_i) begin
      acc_q <= sum_next;
    end
  end

  // result register only moves on the final sample
  p_result_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(result_o));
endmodule

// File: rtl/adc_avg_seq.sv
module adc_avg_seq #(
  parameter int DATA_W    = 12,
  parameter int CH_W      = 4,
  parameter int NUM_CH    = 10,
  parameter int CODE_W    = 3,
  parameter int MAX_CODE  = 6,
  parameter int LAT_LONG  = 40,
  parameter int LAT_SHORT = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              soft_rst_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [CODE_W-1:0] avg_code_i,
  input  logic              lat_sel_i,
  input  logic              fmt_sel_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic [CH_W-1:0]   chan_sel_o,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              eoc_o
);
  logic [CODE_W-1:0] code;
  logic              clr, add, last;

  adc_avg_ctrl #(
    .CH_W(CH_W), .NUM_CH(NUM_CH), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE),
    .LAT_LONG(LAT_LONG), .LAT_SHORT(LAT_SHORT)
  ) i_ctrl (
    .clk_i, .rst_ni, .start_i, .soft_rst_i, .chan_i, .avg_code_i, .lat_sel_i,
    .smp_valid_i,
    .chan_o(chan_sel_o), .code_o(code), .clr_o(clr), .add_o(add), .last_o(last),
    .busy_o, .done_o, .eoc_o
  );

  adc_avg_acc #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)
  ) i_acc (
    .clk_i, .rst_ni, .clr_i(clr), .add_i(add), .last_i(last), .fmt_sel_i,
    .code_i(code), .data_i(smp_data_i), .result_o
  );

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && eoc_o));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_eoc_low_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !eoc_o);

  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!busy_o && !done_o));

  p_reserved_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (chan_i >= CH_W'(NUM_CH))) |=> (!busy_o && $stable(chan_sel_o)));

  p_chan_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(chan_sel_o));
endmodule

// File: tb/test_adc_avg_seq.sv
module test_adc_avg_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic [3:0]  chan_i = '0;
  logic [2:0]  avg_code_i = '0;
  logic        lat_sel_i = 1'b1;
  logic        fmt_sel_i = 1'b1;
  logic        smp_valid_i = 1'b0;
  logic [11:0] smp_data_i = '0;
  logic [3:0]  chan_sel_o;
  logic [11:0] result_o;
  logic        done_o, busy_o, eoc_o;

  int checks = 0;
  int errors = 0;

  adc_avg_seq i_adc_avg_seq (
    .clk_i, .rst_ni, .start_i, .soft_rst_i, .chan_i, .avg_code_i, .lat_sel_i,
    .fmt_sel_i, .smp_valid_i, .smp_data_i, .chan_sel_o, .result_o, .done_o,
    .busy_o, .eoc_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one full conversion; poke=1 issues a start with another channel while busy
  task automatic run_conv(input int chan, input int code, input int lat, input int fmt,
                          input int base, input int step, input bit poke);
    int n, lw, sum, expv, d;
    n   = 1 << ((code > 6) ? 6 : code);
    lw  = lat ? 20 : 40;
    sum = 0;
    @(negedge clk_i);
    start_i = 1'b1; chan_i = 4'(chan); avg_code_i = 3'(code);
    lat_sel_i = 1'(lat); fmt_sel_i = 1'(fmt);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R6 eoc low after start", int'(eoc_o), 0);
    chk("R6 busy after start", int'(busy_o), 1);
    chk("R9 channel latched", int'(chan_sel_o), chan);
    smp_valid_i = 1'b1; smp_data_i = 12'hFFF;
    if (poke) begin start_i = 1'b1; chan_i = 4'h1; end
    for (int i = 0; i < lw; i++) begin
      @(negedge clk_i);
      start_i = 1'b0; chan_i = 4'h2; avg_code_i = 3'd0; fmt_sel_i = ~fmt_sel_i;
    end
    for (int k = 0; k < n; k++) begin
      d = (base + k * step) & 12'hFFF;
      sum += d;
      smp_data_i = 12'(d);
      if (k == n - 1) begin
        chk("R3 still busy before last sample", int'(busy_o), 1);
        chk("R5 no early done", int'(done_o), 0);
      end
      @(negedge clk_i);
    end
    smp_valid_i = 1'b0;
    expv = sum / n;
    if (fmt == 0) expv = expv ^ 12'h800;
    chk("R5 done pulse", int'(done_o), 1);
    chk("R5 eoc set", int'(eoc_o), 1);
    chk("R5 busy cleared", int'(busy_o), 0);
    chk("R1 R2 R4 result", int'(result_o), expv);
    chk("R9 channel held", int'(chan_sel_o), chan);
    @(negedge clk_i);
    chk("R5 done single cycle", int'(done_o), 0);
  endtask

  task automatic t_reset();
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 done", int'(done_o), 0);
    chk("R10 eoc", int'(eoc_o), 0);
    chk("R10 result", int'(result_o), 0);
    chk("R10 chan", int'(chan_sel_o), 0);
  endtask

  task automatic t_averaging();
    run_conv(3, 0, 1, 1, 12'h123, 0, 1'b0);
    for (int c = 1; c <= 6; c++) run_conv(c, c, 1, 1, 100 + c, 37, 1'b0);
    run_conv(9, 7, 1, 1, 0, 1, 1'b0);   // R1 code 7 acts as 64
  endtask

  task automatic t_latency();
    run_conv(0, 2, 0, 1, 12'h400, 5, 1'b0);   // R3 long settle
    run_conv(1, 0, 0, 1, 12'h0A5, 0, 1'b0);
  endtask

  task automatic t_format();
    run_conv(4, 2, 1, 0, 12'h100, 1, 1'b0);   // R4 low half
    run_conv(4, 1, 1, 0, 12'hA00, 3, 1'b0);   // R4 high half
  endtask

  task automatic t_reserved();
    for (int ch = 10; ch < 16; ch++) begin
      @(negedge clk_i);
      start_i = 1'b1; chan_i = 4'(ch);
      @(negedge clk_i);
      start_i = 1'b0;
      chk("R8 busy stays low", int'(busy_o), 0);
      chk("R8 eoc kept", int'(eoc_o), 1);
      chk("R8 chan kept", int'(chan_sel_o), 4);
    end
  endtask

  task automatic t_busy_start();
    run_conv(5, 3, 1, 1, 12'h200, 11, 1'b1);  // R9
  endtask

  task automatic t_abort();
    @(negedge clk_i);
    start_i = 1'b1; chan_i = 4'd6; avg_code_i = 3'd3; lat_sel_i = 1'b1; fmt_sel_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    smp_valid_i = 1'b1; smp_data_i = 12'hFFF;
    repeat (24) @(negedge clk_i);
    soft_rst_i = 1'b1;
    @(negedge clk_i);
    soft_rst_i = 1'b0; smp_valid_i = 1'b0;
    chk("R7 idle after abort", int'(busy_o), 0);
    chk("R7 no done", int'(done_o), 0);
    chk("R7 eoc low", int'(eoc_o), 0);
    repeat (10) @(negedge clk_i);
    chk("R7 still no done", int'(done_o), 0);
    chk("R7 eoc still low", int'(eoc_o), 0);
    run_conv(7, 3, 1, 1, 12'h010, 2, 1'b0);   // R7 no partial sum carried
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_averaging();
    t_latency();
    t_format();
    t_reserved();
    t_busy_start();
    t_abort();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL R0 watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule